// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a retriggerable watchdog. Once it has been armed by a refresh strobe, it counts enabled events. If no further strobe arrives before the count reaches the terminal value of the selected tap, it raises a one-clock reset request. Each later strobe restarts the count from zero. Software keeps the system alive by strobing within the timeout.

A write-only 8-bit mode register holds the configuration: the timeout tap, whether counting continues in halt and in stop, and whether the count source is an internal oscillator tick or every system clock. The register accepts writes only for a fixed window of clocks after a system reset, a watchdog reset or an exit from stop. After that window it is locked. Because the configuration is only writable early in a boot or wake sequence, a runaway program cannot later disable or slow the watchdog.

Top module: `wdg_timer`

## Requirements
- R1: After reset the timer is disarmed, and the reset request stays low for any number of clocks until the first refresh strobe.
- R2: A refresh strobe arms the timer and clears the count. The reset request rises right after the clock edge carrying the T-th enabled count event that follows the most recent strobe, where T is the terminal count.
- R3: Mode bits [1:0] select T = TAP_BASE × 1, 2, 4 or 16 for the codes 00, 01, 10 and 11. The default after reset is 01.
- R4: Mode bit 4 selects the count source. At 0 (the default) the counter advances only on clocks where osc_tick_i is high. At 1 it advances on every clock.
- R5: Mode bit 2 set (the default) lets counting continue while halt_i is high. When it is clear, the count is frozen during halt.
- R6: Mode bit 3 set (the default) lets counting continue while stop_i is high. When it is clear, the count is frozen during stop.
- R7: A write changes the mode only when wr_addr_i equals MODE_ADDR (0x0F) and the write falls on one of the first WINDOW (64) clock edges after a reset release. On any other edge, and for any other address, the write has no effect.
- R8: A falling edge of stop_i (stop recovery) reopens the WINDOW-clock write window and keeps the current mode.
- R9: The reset request is high for exactly one clock. It then restores the default mode, disarms the timer and reopens the write window.
- R10: Mode bits [7:5] are reserved. Their written value has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| kick_i | input | 1 | Refresh strobe: arms the timer and restarts the count |
| halt_i | input | 1 | Processor is in halt |
| stop_i | input | 1 | Processor is in stop; a falling edge marks stop recovery |
| osc_tick_i | input | 1 | One-clock tick from the internal oscillator |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| wdt_rst_o | output | 1 | Registered one-clock reset request |

## Verification
The assertions check on every cycle the properties that are local to one register or one edge:
- the reset request lasts one clock;
- a disarmed timer stays quiet;
- a strobe clears and arms the counter;
- a gated-off cycle freezes the count;
- a closed window keeps the mode unchanged;
- a watchdog reset restores defaults and reopens the window.

Only the bench scenarios can show the end-to-end timing. These cover:
- the exact terminal count for every tap in both source modes;
- the added delay from halt or stop freezes;
- the exact first-rejected edge of the write window;
- that a stop exit and a watchdog reset really make later writes take effect.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Field order matches the write-data bit positions [4:0].
  typedef struct packed {
    logic       ext_src;   // bit 4
    logic       run_stop;  // bit 3
    logic       run_halt;  // bit 2
    logic [1:0] tap;       // bits 1:0
  } wdg_mode_t;

  localparam int MODE_BITS = $bits(wdg_mode_t);

  localparam wdg_mode_t MODE_DEFAULT = '{
    ext_src:  1'b0,
    run_stop: 1'b1,
    run_halt: 1'b1,
    tap:      2'b01
  };

  // Terminal count multiplier exponent per tap code: x1, x2, x4, x16.
  function automatic int unsigned tap_shift(input logic [1:0] code);
    case (code)
      2'b00:   return 0;
      2'b01:   return 1;
      2'b10:   return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/wdg_mode_reg.sv
module wdg_mode_reg
  import wdg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int MODE_ADDR = 8'h0F,
  parameter int WINDOW    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wdt_fire,
  input  logic              stop_exit,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output wdg_mode_t         mode,
  output logic              win_open
);

  localparam int WIN_W = $clog2(WINDOW + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW);

  logic [WIN_W-1:0] win_cnt_q;
  wdg_mode_t        mode_q;
  logic             wr_hit;
  logic             unused_rsvd;

  assign win_open    = (win_cnt_q < WIN_LAST);
  assign wr_hit      = wr_en && (wr_addr == ADDR_W'(MODE_ADDR)) && win_open;
  assign unused_rsvd = ^wr_data[DATA_W-1:MODE_BITS];
  assign mode        = mode_q;

  always_ff @(posedge clk) begin
    if (rst || wdt_fire) begin
      mode_q    <= MODE_DEFAULT;
      win_cnt_q <= '0;
    end else begin
      if (stop_exit) begin
        win_cnt_q <= '0;
      end else if (win_open) begin
        win_cnt_q <= win_cnt_q + 1'b1;
      end
      if (wr_hit) begin
        mode_q <= wdg_mode_t'(wr_data[MODE_BITS-1:0]);
      end
    end
  end

  // R7
  mode_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (!win_open && !wdt_fire) |=> $stable(mode_q));

  // R7
  win_bound_chk: assert property (@(posedge clk) disable iff (rst)
    win_cnt_q <= WIN_LAST);

  // R8
  stop_reopen_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_exit && !wdt_fire) |=> (win_open && $stable(mode_q)));

  // R9
  fire_default_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_fire |=> (mode_q == MODE_DEFAULT && win_open));

endmodule

// File: rtl/wdg_gate.sv
module wdg_gate
  import wdg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  wdg_mode_t mode,
  input  logic      halt,
  input  logic      stop,
  input  logic      osc_tick,
  output logic      count_en,
  output logic      stop_exit
);

  logic stop_q;
  logic src_evt;
  logic halt_block;
  logic stop_block;

  always_ff @(posedge clk) begin
    if (rst) stop_q <= 1'b0;
    else     stop_q <= stop;
  end

  assign stop_exit  = stop_q && !stop;
  assign src_evt    = mode.ext_src || osc_tick;
  assign halt_block = halt && !mode.run_halt;
  assign stop_block = stop && !mode.run_stop;
  assign count_en   = src_evt && !halt_block && !stop_block;

  // R8
  stop_exit_once_chk: assert property (@(posedge clk) disable iff (rst)
    stop_exit |=> !stop_exit);

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int TAP_BASE = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       kick,
  input  logic       count_en,
  input  logic [1:0] tap,
  output logic       fire,
  output logic       armed
);

  localparam int CNT_W  = $clog2(TAP_BASE * 16);
  localparam int NTAPS  = 4;

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             fire_q;
  logic [CNT_W:0]   term_tbl [NTAPS];
  logic [CNT_W:0]   term_sel;
  logic [CNT_W:0]   cnt_next;
  logic             at_term;

  for (genvar g = 0; g < NTAPS; g++) begin : g_term
    assign term_tbl[g] = (CNT_W+1)'(TAP_BASE) << tap_shift(2'(g));
  end

  assign term_sel = term_tbl[tap];
  assign cnt_next = {1'b0, cnt_q} + 1'b1;
  assign at_term  = (cnt_next >= term_sel);

  always_ff @(posedge clk) begin
    if (rst || fire_q) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (kick) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (armed_q && count_en) begin
        if (at_term) begin
          fire_q  <= 1'b1;
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_next[CNT_W-1:0];
        end
      end
    end
  end

  assign fire  = fire_q;
  assign armed = armed_q;

  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    fire_q |=> !fire_q);

  // R1
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !armed_q |=> !fire_q);

  // R2
  kick_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (kick && !fire_q) |=> (armed_q && cnt_q == '0));

  // R5
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !count_en && !kick && !fire_q) |=> $stable(cnt_q));

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int MODE_ADDR = 8'h0F,
  parameter int WINDOW    = 64,
  parameter int TAP_BASE  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick_i,
  input  logic              halt_i,
  input  logic              stop_i,
  input  logic              osc_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wdt_rst_o
);

  wdg_mode_t mode;
  logic      win_open;
  logic      count_en;
  logic      stop_exit;
  logic      fire;
  logic      armed;
  logic      unused_armed;

  wdg_mode_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_ADDR(MODE_ADDR), .WINDOW(WINDOW)
  ) u_mode (
    .clk(clk), .rst(rst), .wdt_fire(fire), .stop_exit(stop_exit),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .mode(mode), .win_open(win_open)
  );

  wdg_gate u_gate (
    .clk(clk), .rst(rst), .mode(mode), .halt(halt_i), .stop(stop_i),
    .osc_tick(osc_tick_i), .count_en(count_en), .stop_exit(stop_exit)
  );

  wdg_counter #(.TAP_BASE(TAP_BASE)) u_cnt (
    .clk(clk), .rst(rst), .kick(kick_i), .count_en(count_en),
    .tap(mode.tap), .fire(fire), .armed(armed)
  );

  assign wdt_rst_o    = fire;
  assign unused_armed = armed ^ win_open;

  // R7
  window_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !win_open && !fire) |=> $stable(mode));

endmodule

// File: tb/tb_wdg_timer.sv
`timescale 1ns/1ps
module tb_wdg_timer;

  localparam int BASE = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       kick_i = 1'b0, halt_i = 1'b0, stop_i = 1'b0, osc_tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_addr_i = 8'h00, wr_data_i = 8'h00;
  logic       wdt_rst_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  wdg_timer #(.TAP_BASE(BASE)) dut (
    .clk(clk), .rst(rst), .kick_i(kick_i), .halt_i(halt_i), .stop_i(stop_i),
    .osc_tick_i(osc_tick_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .wdt_rst_o(wdt_rst_o)
  );

  function automatic int term(input int tap);
    int sh;
    sh = (tap == 3) ? 4 : tap;
    return BASE << sh;
  endfunction

  function automatic logic [7:0] mbyte(input int rsvd, input bit src,
                                       input bit rstop, input bit rhalt, input int tap);
    return {3'(rsvd), src, rstop, rhalt, 2'(tap)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; kick_i = 0; halt_i = 0; stop_i = 0; osc_tick_i = 0; wr_en_i = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Drive a write so that it lands on the n-th edge from the current negedge.
  task automatic wr_at(input int n, input logic [7:0] addr, input logic [7:0] data);
    repeat (n - 1) @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = addr; wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic do_kick();
    kick_i = 1'b1;
    @(negedge clk);
    kick_i = 1'b0;
  endtask

  // Returns the edge index (after the kick) right after which the request was
  // first seen, or 0. Ticks (if enabled) fall on odd edges. Freeze holds halt or
  // stop high on edges fz_start+1 .. fz_start+fz_len.
  task automatic measure(input bit tickmode, input int fz_start, input int fz_len,
                         input bit fz_stop, input int limit, output int first);
    first = 0;
    for (int n = 1; n <= limit; n++) begin
      osc_tick_i = tickmode ? ((n % 2) == 1) : 1'b0;
      if (n > fz_start && n <= fz_start + fz_len) begin
        halt_i = !fz_stop; stop_i = fz_stop;
      end else begin
        halt_i = 1'b0; stop_i = 1'b0;
      end
      @(negedge clk);
      if (wdt_rst_o) begin
        first = n;
        break;
      end
    end
    osc_tick_i = 0; halt_i = 0; stop_i = 0;
    if (first != 0) begin
      @(negedge clk);
      chk(wdt_rst_o == 1'b0, "R9 request one clock wide", int'(wdt_rst_o), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int f;
    int exp;

    // Reset state
    do_reset();
    chk(wdt_rst_o == 1'b0, "R1 reset state", int'(wdt_rst_o), 0);

    // R1: no strobe, ticks running, never fires
    measure(1'b1, 0, 0, 1'b0, 600, f);
    chk(f == 0, "R1 disarmed without strobe", f, 0);

    // R3/R4 defaults: internal tick, tap 01
    do_reset();
    do_kick();
    measure(1'b1, 0, 0, 1'b0, 1000, f);
    exp = 2 * term(1) - 1;
    chk(f == exp, "R3 R4 default tap and source", f, exp);

    // R3/R4/R10 sweep over all taps and sources, reserved bits nonzero
    for (int src = 0; src < 2; src++) begin
      for (int tap = 0; tap < 4; tap++) begin
        do_reset();
        wr_at(5, 8'h0F, mbyte(tap * 2 + src + 1, src[0], 1'b1, 1'b1, tap));
        do_kick();
        measure(src == 0, 0, 0, 1'b0, 1000, f);
        exp = (src == 1) ? term(tap) : 2 * term(tap) - 1;
        chk(f == exp, $sformatf("R3 R4 R10 tap=%0d src=%0d", tap, src), f, exp);
      end
    end

    // R2: restrike mid-count restarts from zero
    do_reset();
    wr_at(3, 8'h0F, mbyte(0, 1'b1, 1'b1, 1'b1, 0));
    do_kick();
    measure(1'b0, 0, 0, 1'b0, 12, f);
    chk(f == 0, "R2 no request before terminal", f, 0);
    do_kick();
    measure(1'b0, 0, 0, 1'b0, 100, f);
    chk(f == term(0), "R2 restart after second strobe", f, term(0));

    // R5: halt freezes when bit 2 clear, not when set
    do_reset();
    wr_at(3, 8'h0F, mbyte(0, 1'b1, 1'b1, 1'b0, 1));
    do_kick();
    measure(1'b0, 5, 10, 1'b0, 200, f);
    chk(f == term(1) + 10, "R5 halt freezes count", f, term(1) + 10);
    do_reset();
    wr_at(3, 8'h0F, mbyte(0, 1'b1, 1'b1, 1'b1, 1));
    do_kick();
    measure(1'b0, 5, 10, 1'b0, 200, f);
    chk(f == term(1), "R5 halt counts when enabled", f, term(1));

    // R6: stop freezes when bit 3 clear, not when set
    do_reset();
    wr_at(3, 8'h0F, mbyte(0, 1'b1, 1'b0, 1'b1, 1));
    do_kick();
    measure(1'b0, 5, 10, 1'b1, 200, f);
    chk(f == term(1) + 10, "R6 stop freezes count", f, term(1) + 10);
    do_reset();
    wr_at(3, 8'h0F, mbyte(0, 1'b1, 1'b1, 1'b1, 1));
    do_kick();
    measure(1'b0, 5, 10, 1'b1, 200, f);
    chk(f == term(1), "R6 stop counts when enabled", f, term(1));

    // R7: last open edge (64) accepted
    do_reset();
    wr_at(64, 8'h0F, mbyte(0, 1'b1, 1'b1, 1'b1, 0));
    do_kick();
    measure(1'b0, 0, 0, 1'b0, 100, f);
    chk(f == term(0), "R7 write on edge 64 accepted", f, term(0));

    // R7: edge 65 rejected (no ticks, so default internal source never fires)
    do_reset();
    wr_at(65, 8'h0F, mbyte(0, 1'b1, 1'b1, 1'b1, 0));
    do_kick();
    measure(1'b0, 0, 0, 1'b0, 100, f);
    chk(f == 0, "R7 write on edge 65 ignored", f, 0);

    // R7: wrong address ignored
    do_reset();
    wr_at(5, 8'h0E, mbyte(0, 1'b1, 1'b1, 1'b1, 0));
    do_kick();
    measure(1'b0, 0, 0, 1'b0, 100, f);
    chk(f == 0, "R7 other address ignored", f, 0);

    // R8: stop recovery reopens the window
    do_reset();
    repeat (100) @(negedge clk);
    stop_i = 1'b1;
    repeat (3) @(negedge clk);
    stop_i = 1'b0;
    wr_at(3, 8'h0F, mbyte(0, 1'b1, 1'b1, 1'b1, 0));
    do_kick();
    measure(1'b0, 0, 0, 1'b0, 100, f);
    chk(f == term(0), "R8 write after stop exit accepted", f, term(0));

    // R9: watchdog reset reopens window and restores defaults
    do_reset();
    wr_at(3, 8'h0F, mbyte(0, 1'b1, 1'b1, 1'b1, 0));
    do_kick();
    measure(1'b0, 0, 0, 1'b0, 100, f);
    chk(f == term(0), "R9 first timeout", f, term(0));
    wr_at(2, 8'h0F, mbyte(0, 1'b1, 1'b1, 1'b1, 2));
    do_kick();
    measure(1'b0, 0, 0, 1'b0, 200, f);
    chk(f == term(2), "R9 window reopened after timeout", f, term(2));
    measure(1'b0, 0, 0, 1'b0, 80, f);
    chk(f == 0, "R9 disarmed after timeout", f, 0);
    do_kick();
    measure(1'b1, 0, 0, 1'b0, 1000, f);
    exp = 2 * term(1) - 1;
    chk(f == exp, "R9 defaults restored after timeout", f, exp);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule